// File: doc/BRIEF.md
# Nonblocking Direct-Mapped Read Cache with Line-Fill Buffers

This block is a direct-mapped read cache placed between a 32-bit processor local bus and an external memory that returns whole lines as four-longword bursts. Lines are 16 bytes long. With the default of 128 lines the cache holds 2 KB, which is 512 longwords. Each line in the storage array has one valid bit, so the array only ever receives complete lines.

Two line-fill buffers sit next to the array, one for instruction fetches and one for data fetches. Each buffer holds one line and keeps a valid bit for every longword in it. A fetch is compared against the array and against the buffer picked by its type, and a hit in either place completes in one cycle. When a fetch misses both, the cache asks external memory for the line. The burst starts at the requested longword, and each longword is placed in the buffer as it arrives. The processor bus is released as soon as the missed longword has been delivered. After that, hits are served while the rest of the line streams in, including hits on longwords of the partly filled buffer that have already arrived. A complete line is moved from a buffer into the array when that buffer is next claimed by a miss.

Top module: `nbc_cache`

## Requirements
- R1: An address splits into a longword select in bits [3:2], a line index in bits [4+IDX_W-1:4] (IDX_W = log2 LINES, 7 by default) and a tag in the bits above. Fetches that differ only in bits [3:0] share one line.
- R2: When a fetch hits, `req_ready` is high in the same cycle. In the following cycle `rsp_valid` is high and `rsp_data` carries that longword. No burst is issued.
- R3: When a fetch misses both the array and its selected buffer, and no burst is in progress, `mem_req_valid` is high for exactly one cycle, starting the cycle after the miss. `mem_req_addr` equals the fetch address with bits [1:0] cleared.
- R4: A burst delivers four beats on `mem_rvalid`/`mem_rdata`. The beats carry longwords in ascending order starting at the critical longword and wrapping modulo 4. Each beat marks its longword valid in the buffer.
- R5: A fetch stalled by its own miss is accepted in the cycle after the beat carrying its longword is captured. It then receives the correct data.
- R6: Longwords of a partly filled buffer that have already arrived are hits while the burst continues. Longwords that have not arrived yet are not hits and do not start another burst.
- R7: While a burst is in progress, hits in the storage array are served without waiting.
- R8: A miss that occurs while a burst is in progress stalls until the last beat of that burst. Only then is its own burst issued. Two bursts never overlap.
- R9: When a miss claims a buffer that holds a complete line, that line is written into the array. A later fetch of it hits without a burst.
- R10: `req_instr` = 1 selects the instruction buffer and 0 selects the data buffer. A line present only in the other buffer does not count as a hit.
- R11: While `invalidate` is high, `req_ready` is low. From the next cycle on, every array line and every buffer longword is invalid. Beats still arriving from a burst that was in progress are discarded.
- R12: A line loaded into an index replaces the line previously held there. A later fetch of the replaced line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| invalidate | input | 1 | Clear all valid state |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | ADDR_W | Fetch byte address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data fetch |
| req_ready | output | 1 | Fetch accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Burst request pulse |
| mem_req_addr | output | ADDR_W | Critical longword address of the burst |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The bench builds the cache with LINES = 8, so the index is bits [6:4]. With so few lines, two addresses that differ only above bit 6 collide often. Replacement and commits from the buffers into the array then occur many times within a few hundred random fetches. The bench can slow the memory model down by inserting a gap of several cycles between beats. This keeps a burst open long enough to reach the partial-buffer hits, the array hits during a burst, the stalls behind a burst in progress, and an invalidate that arrives in the middle of a burst.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int WSEL_W         = 2;
    localparam int OFFSET_W       = 4;
    localparam int LINE_BITS      = WORDS_PER_LINE * 32;

    typedef logic [31:0] word_t;
    typedef logic [WORDS_PER_LINE-1:0][31:0] line_t;
endpackage

// File: rtl/nbc_fill_buf.sv
module nbc_fill_buf
    import nbc_pkg::*;
#(
    parameter int LINE_ID_W = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 alloc,
    input  logic [LINE_ID_W-1:0] alloc_line,
    input  logic                 wr_en,
    input  logic [WSEL_W-1:0]    wr_sel,
    input  word_t                wr_data,
    input  logic [LINE_ID_W-1:0] look_line,
    input  logic [WSEL_W-1:0]    look_sel,
    output logic                 hit,
    output word_t                hit_data,
    output logic                 full,
    output logic [LINE_ID_W-1:0] line_id,
    output line_t                line_data
);
    typedef struct packed {
        logic [LINE_ID_W-1:0]      line;
        logic [WORDS_PER_LINE-1:0] vld;
        line_t                     data;
    } fb_t;

    fb_t fb_d, fb_q;

    always_comb begin
        fb_d = fb_q;
        if (clr) begin
            fb_d.vld = '0;
        end else if (alloc) begin
            fb_d.line = alloc_line;
            fb_d.vld  = '0;
        end
        if (wr_en) begin
            fb_d.data[wr_sel] = wr_data;
            fb_d.vld[wr_sel]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign hit       = fb_q.vld[look_sel] && (fb_q.line == look_line);
    assign hit_data  = fb_q.data[look_sel];
    assign full      = &fb_q.vld;
    assign line_id   = fb_q.line;
    assign line_data = fb_q.data;
endmodule

// File: rtl/nbc_store.sv
module nbc_store
    import nbc_pkg::*;
#(
    parameter int LINES = 128,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inv,
    input  logic [$clog2(LINES)-1:0] look_idx,
    input  logic [TAG_W-1:0]         look_tag,
    input  logic [WSEL_W-1:0]        look_sel,
    output logic                     hit,
    output word_t                    rdata,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  line_t                    wr_data
);
    logic [LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0] tag_mem  [LINES];
    line_t            data_mem [LINES];

    always_comb begin
        vld_d = vld_q;
        if (inv)        vld_d = '0;
        else if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    // Storage holds no reset: the valid bits guard it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign hit   = vld_q[look_idx] && (tag_mem[look_idx] == look_tag);
    assign rdata = data_mem[look_idx][look_sel];
endmodule

// File: rtl/nbc_cache.sv
module nbc_cache
    import nbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_instr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    localparam int IDX_W     = $clog2(LINES);
    localparam int LINE_ID_W = ADDR_W - OFFSET_W;
    localparam int TAG_W     = LINE_ID_W - IDX_W;
    localparam int NBUF      = 2;

    typedef struct packed {
        logic              busy;
        logic              drop;
        logic              sel;
        logic [1:0]        cnt;
        logic [WSEL_W-1:0] wsel;
        logic              mreq;
        logic [ADDR_W-1:0] maddr;
        logic              rvld;
        word_t             rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINE_ID_W-1:0] look_line;
    logic [WSEL_W-1:0]    look_sel;
    logic                 st_hit, sbuf_hit, hit, start, beat, beat_wr, commit;
    word_t                st_data, sbuf_data;
    logic                 unused_lsb;

    logic [NBUF-1:0]      buf_hit, buf_full, buf_alloc, buf_wr;
    word_t                buf_data  [NBUF];
    logic [LINE_ID_W-1:0] buf_line  [NBUF];
    line_t                buf_ldata [NBUF];

    assign look_line  = req_addr[ADDR_W-1:OFFSET_W];
    assign look_sel   = req_addr[3:2];
    assign unused_lsb = ^req_addr[1:0];

    assign sbuf_hit  = buf_hit[req_instr];
    assign sbuf_data = buf_data[req_instr];
    assign hit       = st_hit || sbuf_hit;
    assign req_ready = hit && !invalidate;
    assign start     = req_valid && !hit && !invalidate && !ctl_q.busy;
    assign beat      = ctl_q.busy && mem_rvalid;
    assign beat_wr   = beat && !ctl_q.drop && !invalidate;
    assign commit    = start && buf_full[req_instr];

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        assign buf_alloc[g] = start && (req_instr == 1'(g));
        assign buf_wr[g]    = beat_wr && (ctl_q.sel == 1'(g));

        nbc_fill_buf #(.LINE_ID_W(LINE_ID_W)) i_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (invalidate),
            .alloc      (buf_alloc[g]),
            .alloc_line (look_line),
            .wr_en      (buf_wr[g]),
            .wr_sel     (ctl_q.wsel),
            .wr_data    (mem_rdata),
            .look_line  (look_line),
            .look_sel   (look_sel),
            .hit        (buf_hit[g]),
            .hit_data   (buf_data[g]),
            .full       (buf_full[g]),
            .line_id    (buf_line[g]),
            .line_data  (buf_ldata[g])
        );
    end

    nbc_store #(.LINES(LINES), .TAG_W(TAG_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv      (invalidate),
        .look_idx (look_line[IDX_W-1:0]),
        .look_tag (look_line[LINE_ID_W-1:IDX_W]),
        .look_sel (look_sel),
        .hit      (st_hit),
        .rdata    (st_data),
        .wr_en    (commit),
        .wr_idx   (buf_line[req_instr][IDX_W-1:0]),
        .wr_tag   (buf_line[req_instr][LINE_ID_W-1:IDX_W]),
        .wr_data  (buf_ldata[req_instr])
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.mreq  = 1'b0;
        ctl_d.rvld  = req_valid && req_ready;
        ctl_d.rdata = sbuf_hit ? sbuf_data : st_data;
        if (invalidate && ctl_q.busy) ctl_d.drop = 1'b1;
        if (start) begin
            ctl_d.busy  = 1'b1;
            ctl_d.drop  = 1'b0;
            ctl_d.sel   = req_instr;
            ctl_d.cnt   = '0;
            ctl_d.wsel  = look_sel;
            ctl_d.mreq  = 1'b1;
            ctl_d.maddr = {req_addr[ADDR_W-1:2], 2'b00};
        end
        if (beat) begin
            ctl_d.wsel = ctl_q.wsel + 1'b1;
            ctl_d.cnt  = ctl_q.cnt + 1'b1;
            if (ctl_q.cnt == 2'd3) begin
                ctl_d.busy = 1'b0;
                ctl_d.drop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rsp_valid     = ctl_q.rvld;
    assign rsp_data      = ctl_q.rdata;
    assign mem_req_valid = ctl_q.mreq;
    assign mem_req_addr  = ctl_q.maddr;
endmodule

// File: rtl/nbc_cache_chk.sv
module nbc_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic invalidate,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic mem_req_valid,
    input logic mem_rvalid
);
    logic [2:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          pend_q <= '0;
        else if (mem_req_valid)              pend_q <= mem_rvalid ? 3'd3 : 3'd4;
        else if (mem_rvalid && pend_q != 0)  pend_q <= pend_q - 3'd1;
    end

    assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);
    assert_req_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    assert_no_overlap_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (pend_q == 3'd0));
    assert_inv_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> !req_ready);
    assert_inv_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !req_ready);
endmodule

bind nbc_cache nbc_cache_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .invalidate    (invalidate),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_rvalid    (mem_rvalid)
);

// File: tb/test_nbc_cache.sv
`timescale 1ns/1ps
module test_nbc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        invalidate = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_instr = 1'b0;
    logic        req_ready, rsp_valid, mem_req_valid;
    logic [31:0] rsp_data, mem_req_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, fails = 0, bursts = 0, beat_gap = 0;
    bit rand_gap = 0, burst_active = 0, saw_busy = 0, done = 0;
    logic [31:0] burst_addr = '0;

    always #2.5 clk = ~clk;

    nbc_cache #(.ADDR_W(32), .LINES(8)) i_nbc_cache (
        .clk(clk), .rst_n(rst_n), .invalidate(invalidate),
        .req_valid(req_valid), .req_addr(req_addr), .req_instr(req_instr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'hC3A50F1E;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: wrap-ordered four-beat bursts from the critical longword (R4)
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                burst_addr = mem_req_addr;
                burst_active = 1;
                bursts++;
                for (int b = 0; b < 4; b++) begin
                    int g;
                    g = rand_gap ? int'($urandom_range(0, 2)) : beat_gap;
                    repeat (g) @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_word({burst_addr[31:4], 2'(burst_addr[3:2] + 2'(b)), 2'b00});
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
                burst_active = 0;
            end
        end
    end

    // One fetch; called just after a negedge. Returns cycles waited before acceptance.
    task automatic rd(input logic [31:0] a, input logic ins, input string req, output int waits);
        req_valid = 1'b1; req_addr = a; req_instr = ins;
        waits = 0;
        #1;
        saw_busy = burst_active;
        while (!req_ready && waits < 2000) begin
            @(negedge clk); #1;
            waits++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(rsp_valid === 1'b1 && rsp_data === mem_word(a), req, rsp_data, mem_word(a));
    endtask

    task automatic settle();
        while (burst_active) begin @(negedge clk); end
        @(negedge clk); @(negedge clk); #1;
    endtask

    initial begin
        int w, nb;
        logic [31:0] a;
        $urandom(32'h5EED_1234);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(rsp_valid === 0 && mem_req_valid === 0, "R2 reset outputs idle", {rsp_valid, mem_req_valid}, 0);
        req_valid = 1; req_addr = 32'h102B; #1;
        check(req_ready === 0, "R2 reset empty", req_ready, 0);
        req_valid = 0;
        @(negedge clk); #1;

        // R3 R4 R5: first miss
        nb = bursts;
        rd(32'h0000_102B, 0, "R5 miss data", w);
        check(w > 0, "R5 miss stalls", w, 1);
        check(bursts == nb + 1, "R3 one burst", bursts, nb + 1);
        check(burst_addr == 32'h0000_1028, "R3 critical address", burst_addr, 32'h1028);
        settle();
        nb = bursts;
        for (int k = 0; k < 4; k++) begin
            rd(32'h1020 + 32'(4 * k), 0, "R4 R1 filled words", w);
            check(w == 0, "R4 R1 same line hit", w, 0);
        end
        check(bursts == nb, "R2 no burst on hit", bursts, nb);

        // R6 R7 R9: slow burst for B (commits A into array)
        beat_gap = 8;
        rd(32'h0000_2034, 0, "R6 B miss", w);
        rd(32'h0000_2034, 0, "R6 arrived word", w);
        check(w == 0 && burst_active, "R6 partial hit", w, 0);
        rd(32'h0000_1024, 0, "R7 R9 array hit data", w);
        check(w == 0 && burst_active, "R7 R9 array hit during burst", w, 0);
        nb = bursts;
        rd(32'h0000_2038, 0, "R6 pending word data", w);
        check(w > 0, "R6 pending word not hit", w, 1);
        check(bursts == nb, "R6 no extra burst", bursts, nb);

        // R8: miss during burst stalls until it ends
        nb = bursts;
        rd(32'h0000_3048, 1, "R8 stalled miss data", w);
        check(saw_busy && bursts == nb + 1, "R8 stall then own burst", bursts, nb + 1);
        check(burst_addr == 32'h3048, "R8 new burst address", burst_addr, 32'h3048);
        beat_gap = 0;
        settle();

        // R10: line only in instruction buffer misses for a data fetch
        rd(32'h0000_3048, 1, "R10 I hit data", w);
        check(w == 0, "R10 I buffer hit", w, 0);
        nb = bursts;
        rd(32'h0000_304C, 0, "R10 D data", w);
        check(bursts == nb + 1, "R10 other buffer ignored", bursts, nb + 1);
        settle();

        // R12: same index, other tag replaces (index bits [6:4]=2)
        rd(32'h0000_10A8, 0, "R12 D line", w); settle();
        rd(32'h0000_4054, 0, "R12 push", w); settle();
        nb = bursts;
        rd(32'h0000_1028, 0, "R12 replaced data", w);
        check(bursts == nb + 1, "R12 replaced misses", bursts, nb + 1);
        settle();

        // R11: invalidate
        req_valid = 1; req_addr = 32'h4054; req_instr = 0; invalidate = 1; #1;
        check(req_ready === 0, "R11 ready low during invalidate", req_ready, 0);
        @(negedge clk); invalidate = 0; req_valid = 0; #1;
        nb = bursts;
        rd(32'h0000_4054, 0, "R11 after invalidate data", w);
        check(bursts == nb + 1, "R11 line invalidated", bursts, nb + 1);
        settle();
        beat_gap = 6;
        nb = bursts;
        rd(32'h0000_5060, 0, "R11 F miss", w);
        invalidate = 1; @(negedge clk); invalidate = 0; #1;
        rd(32'h0000_5060, 0, "R11 discard data", w);
        check(bursts == nb + 2, "R11 beats discarded", bursts, nb + 2);
        beat_gap = 0;
        settle();

        // Random traffic
        rand_gap = 1;
        for (int n = 0; n < 400; n++) begin
            a = {23'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), 2'b00};
            if ($urandom_range(0, 49) == 0) begin
                invalidate = 1; @(negedge clk); invalidate = 0; #1;
            end
            rd(a, 1'($urandom_range(0, 1)), "R2 R4 random data", w);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule